// File: doc/BRIEF.md
# DDR SDRAM Command Monitor

This block sits beside the control pins of a double-data-rate SDRAM and samples them on every rising clock edge. From the clock-enable level of the previous and current cycle, the chip-select, row strobe, column strobe and write-enable lines, the address bus and the bank-address bits, it produces one command code per cycle. It also keeps a model of the four banks (open, idle, or held in a precharge window) and a model of the device power state.

The monitor is meant for protocol checking in simulation-grade or on-chip debug logic. It reports three kinds of fault, each as a one-cycle pulse:
- a command that does not fit the addressed bank's state;
- an activate that arrives while a bank is still inside its precharge or auto-precharge window;
- a mode-register write issued while any bank is open or still precharging.

Burst length, the precharge period and the write-recovery period are static configuration inputs. They set the length of each bank's lockout window.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With clock enable high in both cycles, the pins decode to these `cmd_code` values: NOP 0, deselect (CS high) 1, activate 2, read 3, read with auto-precharge 4, write 5, write with auto-precharge 6, precharge one bank 7, precharge all 8, burst stop 9, auto refresh 10, mode-register write 11, extended mode-register write 12. Self-refresh entry is 13, power-down entry 14, clock-enable rise (exit) 15, and clock enable held low 16. The strobe patterns (RAS, CAS, WE, active low) are: 011 activate, 101 read, 100 write, 010 precharge, 110 burst stop, 001 refresh, 000 mode register, 111 NOP.
- R2: Address bit 10 high selects the auto-precharge form of read and write. On a precharge, address bit 10 high closes every bank whatever the bank bits are; with bit 10 low, only the addressed bank closes.
- R3: A mode-register write with bank bit 0 high decodes as the extended form. Every mode-register write loads `mode_op` with {bank bits, address}.
- R4: A mode-register write of either form pulses `mode_viol` when any bank is open, or when fewer than `cfg_trp` cycles have passed since the last precharge.
- R5: An activate to an idle bank opens it. After a precharge in cycle n, the bank shows in `bank_busy` and may be activated again from cycle n+`cfg_trp`.
- R6: After a read with auto-precharge in cycle n, an activate to that bank before cycle n+BL/2+`cfg_trp` pulses `early_act`, and the bank stays closed. BL is 2, 4 or 8 for `cfg_burst` 0, 1 or 2 (3 acts as 8).
- R7: After a write with auto-precharge in cycle n, an activate to that bank before cycle n+BL/2+1+`cfg_twr`+`cfg_trp` pulses `early_act`, and the bank stays closed.
- R8: `illegal_cmd` pulses for a read, write or burst stop addressed to a bank that is not open, and for an activate to a bank that is already open.
- R9: A clock-enable fall carrying the refresh pattern is self-refresh entry and sets `pwr_state` to 3. The same pattern with clock enable high in both cycles is an ordinary refresh.
- R10: Any other clock-enable fall sets `pwr_state` to 2 if any bank is open, or to 1 otherwise. A clock-enable rise returns `pwr_state` to 0.
- R11: Every output is registered: the result of the pins sampled at one rising edge is visible just after that edge. The reset state is code 0, all banks idle, no flags, and `pwr_state` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst | input | 2 | Burst length select: 0=2, 1=4, 2 or 3=8 |
| cfg_trp | input | 4 | Precharge period in cycles (at least 1) |
| cfg_twr | input | 4 | Write-recovery period in cycles |
| cke_prev | input | 1 | Clock enable seen in the previous cycle |
| cke_cur | input | 1 | Clock enable in this cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 12 | Address bus; bit 10 is the auto-precharge flag |
| ba | input | 2 | Bank address |
| cmd_code | output | 5 | Decoded command of the last sampled cycle |
| bank_open | output | 4 | One bit per bank: row open |
| bank_busy | output | 4 | One bit per bank: inside a precharge window |
| illegal_cmd | output | 1 | Command does not fit the bank state |
| early_act | output | 1 | Activate inside a lockout window |
| mode_viol | output | 1 | Mode-register write while banks are not settled |
| pwr_state | output | 2 | 0 awake, 1 precharge power-down, 2 active power-down, 3 self-refresh |
| mode_op | output | 14 | Last mode-register operand {ba, addr} |

## Verification
Every result of the pins sampled at a rising edge is due one edge later and is held for the whole next cycle. The bench changes the pins at the falling edge and reads all outputs 1 ns after the following rising edge, so each check sees exactly the command just issued. For the lockout windows, the bench issues an auto-precharge command in cycle n and an activate k cycles later. It sweeps k across the whole window for every burst length and for several precharge and recovery settings. Each trial expects the violation exactly when k is below the window length, which the bench works out from the burst and timing settings.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [4:0] {
    C_NOP      = 5'd0,
    C_DESEL    = 5'd1,
    C_ACT      = 5'd2,
    C_RD       = 5'd3,
    C_RDA      = 5'd4,
    C_WR       = 5'd5,
    C_WRA      = 5'd6,
    C_PRE      = 5'd7,
    C_PREA     = 5'd8,
    C_BST      = 5'd9,
    C_REF      = 5'd10,
    C_MRS      = 5'd11,
    C_EMRS     = 5'd12,
    C_SREF_IN  = 5'd13,
    C_PD_IN    = 5'd14,
    C_CKE_EXIT = 5'd15,
    C_CKE_HOLD = 5'd16
  } cmd_e;

  typedef enum logic [1:0] {
    P_AWAKE  = 2'd0,
    P_PD_PRE = 2'd1,
    P_PD_ACT = 2'd2,
    P_SREF   = 2'd3
  } pwr_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cke_prev,
  input  logic cke_cur,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic ap,
  input  logic ba0,
  output cmd_e cmd
);

  always_comb begin
    cmd = C_NOP;
    if (cke_prev && !cke_cur) begin
      // falling clock enable: refresh pattern means self-refresh
      if (!cs_n && !ras_n && !cas_n && we_n) cmd = C_SREF_IN;
      else                                   cmd = C_PD_IN;
    end else if (!cke_prev && cke_cur) begin
      cmd = C_CKE_EXIT;
    end else if (!cke_prev) begin
      cmd = C_CKE_HOLD;
    end else if (cs_n) begin
      cmd = C_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b000:  cmd = ba0 ? C_EMRS : C_MRS;
        3'b001:  cmd = C_REF;
        3'b010:  cmd = ap ? C_PREA : C_PRE;
        3'b011:  cmd = C_ACT;
        3'b100:  cmd = ap ? C_WRA : C_WR;
        3'b101:  cmd = ap ? C_RDA : C_RD;
        3'b110:  cmd = C_BST;
        default: cmd = C_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_mon_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  cmd_e             cmd,
  input  logic [CNT_W-1:0] load_pre,
  input  logic [CNT_W-1:0] load_rd,
  input  logic [CNT_W-1:0] load_wr,
  output logic             is_open,
  output logic             is_busy,
  output logic             illegal_hit,
  output logic             early_hit
);

  logic             open_q, open_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act, pre, rda, wra, colcmd, upd;

  assign act    = sel && (cmd == C_ACT);
  assign pre    = (sel && (cmd == C_PRE)) || (cmd == C_PREA);
  assign rda    = sel && (cmd == C_RDA);
  assign wra    = sel && (cmd == C_WRA);
  assign colcmd = sel && (cmd inside {C_RD, C_RDA, C_WR, C_WRA, C_BST});

  assign is_busy     = (cnt_q != '0);
  assign is_open     = open_q;
  assign early_hit   = act && is_busy;
  assign illegal_hit = (act && open_q) || (colcmd && !open_q);
  assign upd         = is_busy || act || pre || rda || wra;

  always_comb begin
    open_d = open_q;
    cnt_d  = cnt_q;
    if (is_busy) cnt_d = cnt_q - 1'b1;
    if (open_q) begin
      if (pre) begin
        open_d = 1'b0;
        cnt_d  = load_pre;
      end else if (rda) begin
        open_d = 1'b0;
        cnt_d  = load_rd;
      end else if (wra) begin
        open_d = 1'b0;
        cnt_d  = load_wr;
      end
    end else if (act && !is_busy) begin
      open_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (upd) begin
      open_q <= open_d;
      cnt_q  <= cnt_d;
    end
  end

  p_act_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !open_q && !is_busy) |=> is_open);
  p_early_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    early_hit |=> !is_open);
  p_autopre_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rda || wra) && open_q) |=> (!is_open && $stable(illegal_hit) || !is_open));

endmodule

// File: rtl/sdram_pwr_track.sv
module sdram_pwr_track
  import sdram_mon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_e cmd,
  input  logic any_open,
  output pwr_e state
);

  pwr_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (cmd)
      C_PD_IN:    st_d = any_open ? P_PD_ACT : P_PD_PRE;
      C_SREF_IN:  st_d = P_SREF;
      C_CKE_EXIT: st_d = P_AWAKE;
      default:    st_d = st_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= P_AWAKE;
    else        st_q <= st_d;
  end

  assign state = st_q;

  p_sref_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_SREF_IN) |=> (state == P_SREF));
  p_cke_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_CKE_EXIT) |=> (state == P_AWAKE));

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter  int NBANK = 4,
  parameter  int ROW_W = 12,
  parameter  int T_W   = 4,
  parameter  int AP_BIT = 10,
  localparam int BA_W  = $clog2(NBANK),
  localparam int OP_W  = ROW_W + BA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_burst,
  input  logic [T_W-1:0]   cfg_trp,
  input  logic [T_W-1:0]   cfg_twr,
  input  logic             cke_prev,
  input  logic             cke_cur,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [ROW_W-1:0] addr,
  input  logic [BA_W-1:0]  ba,
  output logic [4:0]       cmd_code,
  output logic [NBANK-1:0] bank_open,
  output logic [NBANK-1:0] bank_busy,
  output logic             illegal_cmd,
  output logic             early_act,
  output logic             mode_viol,
  output logic [1:0]       pwr_state,
  output logic [OP_W-1:0]  mode_op
);

  localparam int CNT_W = T_W + 2;

  cmd_e             cmd;
  cmd_e             cmd_q;
  logic [NBANK-1:0] ill_v, early_v;
  logic [1:0]       bsel;
  logic [CNT_W-1:0] half, sum_rd, sum_wr, sum_pre;
  logic [CNT_W-1:0] load_rd, load_wr, load_pre;
  logic             is_mrs;
  logic             illegal_q, early_q, mviol_q, mviol_d;
  logic [OP_W-1:0]  op_q;
  pwr_e             pwr;

  function automatic logic [CNT_W-1:0] minus1(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  sdram_cmd_decode u_dec (
    .cke_prev (cke_prev),
    .cke_cur  (cke_cur),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .ap       (addr[AP_BIT]),
    .ba0      (ba[0]),
    .cmd      (cmd)
  );

  // lockout lengths; a load of L-1 lets an activate in at cycle n+L
  assign bsel     = (cfg_burst > 2'd2) ? 2'd2 : cfg_burst;
  assign half     = CNT_W'(1) << bsel;
  assign sum_pre  = CNT_W'(cfg_trp);
  assign sum_rd   = half + CNT_W'(cfg_trp);
  assign sum_wr   = half + CNT_W'(1) + CNT_W'(cfg_twr) + CNT_W'(cfg_trp);
  assign load_pre = minus1(sum_pre);
  assign load_rd  = minus1(sum_rd);
  assign load_wr  = minus1(sum_wr);

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    sdram_bank_track #(.CNT_W(CNT_W)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel         (ba == BA_W'(i)),
      .cmd         (cmd),
      .load_pre    (load_pre),
      .load_rd     (load_rd),
      .load_wr     (load_wr),
      .is_open     (bank_open[i]),
      .is_busy     (bank_busy[i]),
      .illegal_hit (ill_v[i]),
      .early_hit   (early_v[i])
    );
  end

  sdram_pwr_track u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .any_open (|bank_open),
    .state    (pwr)
  );

  assign is_mrs  = (cmd == C_MRS) || (cmd == C_EMRS);
  assign mviol_d = is_mrs && ((|bank_open) || (|bank_busy));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= C_NOP;
      illegal_q <= 1'b0;
      early_q   <= 1'b0;
      mviol_q   <= 1'b0;
    end else begin
      cmd_q     <= cmd;
      illegal_q <= |ill_v;
      early_q   <= |early_v;
      mviol_q   <= mviol_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      op_q <= '0;
    else if (is_mrs) op_q <= {ba, addr};
  end

  assign cmd_code    = cmd_q;
  assign illegal_cmd = illegal_q;
  assign early_act   = early_q;
  assign mode_viol   = mviol_q;
  assign pwr_state   = pwr;
  assign mode_op     = op_q;

  p_mrs_open_viol_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && (|bank_open)) |=> mode_viol);
  p_prea_closes_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PREA) |=> (bank_open == '0));
  p_illegal_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cmd |-> (cmd_q inside {C_ACT, C_RD, C_RDA, C_WR, C_WRA, C_BST}));
  p_early_is_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
    early_act |-> (cmd_q == C_ACT));

endmodule

// File: tb/sdram_cmd_monitor_bench.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_burst;
  logic [3:0]  cfg_trp, cfg_twr;
  logic        cke_prev, cke_cur, cs_n, ras_n, cas_n, we_n;
  logic [11:0] addr;
  logic [1:0]  ba;
  logic [4:0]  cmd_code;
  logic [3:0]  bank_open, bank_busy;
  logic        illegal_cmd, early_act, mode_viol;
  logic [1:0]  pwr_state;
  logic [13:0] mode_op;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  sdram_cmd_monitor u_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cfg_burst(cfg_burst), .cfg_trp(cfg_trp),
    .cfg_twr(cfg_twr), .cke_prev(cke_prev), .cke_cur(cke_cur), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba),
    .cmd_code(cmd_code), .bank_open(bank_open), .bank_busy(bank_busy),
    .illegal_cmd(illegal_cmd), .early_act(early_act), .mode_viol(mode_viol),
    .pwr_state(pwr_state), .mode_op(mode_op)
  );

  task automatic chk(input string req, input int actual, input int expected);
    total++;
    if (actual !== expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // drive at falling edge, sample 1 ns after the next rising edge
  task automatic cyc(input logic kp, input logic kc, input logic c, input logic r,
                     input logic a, input logic w, input logic [11:0] ad,
                     input logic [1:0] b);
    @(negedge clk);
    cke_prev = kp; cke_cur = kc; cs_n = c; ras_n = r; cas_n = a; we_n = w;
    addr = ad; ba = b;
    @(posedge clk);
    #1;
  endtask

  task automatic nop();              cyc(1,1,0,1,1,1,12'h000,2'd0); endtask
  task automatic act(input int b);   cyc(1,1,0,0,1,1,12'h000,2'(b)); endtask
  task automatic pre(input int b);   cyc(1,1,0,0,1,0,12'h000,2'(b)); endtask
  task automatic prea();             cyc(1,1,0,0,1,0,12'h400,2'd1); endtask
  task automatic rd(input int b, input logic ap); cyc(1,1,0,1,0,1,{1'b0,ap,10'd0},2'(b)); endtask
  task automatic wr(input int b, input logic ap); cyc(1,1,0,1,0,0,{1'b0,ap,10'd0},2'(b)); endtask
  task automatic idle(input int n);  for (int i = 0; i < n; i++) nop(); endtask

  function automatic int exp_code(input logic c, input logic r, input logic a,
                                  input logic w, input logic ap, input logic b0);
    if (c) return 1;
    case ({r, a, w})
      3'b000: return b0 ? 12 : 11;
      3'b001: return 10;
      3'b010: return ap ? 8 : 7;
      3'b011: return 2;
      3'b100: return ap ? 6 : 5;
      3'b101: return ap ? 4 : 3;
      3'b110: return 9;
      default: return 0;
    endcase
  endfunction

  initial begin
    #760000;
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_burst = 2'd1; cfg_trp = 4'd2; cfg_twr = 4'd2;
    cke_prev = 1; cke_cur = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1;
    addr = '0; ba = '0;
    #9 rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11 code", cmd_code, 0);
    chk("R11 open", bank_open, 0);
    chk("R11 pwr", pwr_state, 0);
    chk("R11 flags", {illegal_cmd, early_act, mode_viol}, 0);

    // R1 decode sweep with clock enable high
    for (int c = 0; c < 2; c++)
      for (int p = 0; p < 8; p++)
        for (int ap = 0; ap < 2; ap++) begin
          cyc(1,1,1'(c),1'(p>>2),1'(p>>1),1'(p),{1'b0,1'(ap),10'd0},2'd0);
          chk("R1 decode", cmd_code, exp_code(1'(c),1'(p>>2),1'(p>>1),1'(p),1'(ap),1'b0));
        end
    prea(); idle(4);
    chk("R2 all closed", bank_open, 0);

    // R9 / R10 clock-enable transitions
    cyc(1,1,0,0,0,1,12'h0,2'd0); chk("R9 plain refresh", cmd_code, 10);
    chk("R9 awake", pwr_state, 0);
    cyc(1,0,0,0,0,1,12'h0,2'd0); chk("R9 sref code", cmd_code, 13);
    chk("R9 sref state", pwr_state, 3);
    cyc(0,0,1,1,1,1,12'h0,2'd0); chk("R1 hold code", cmd_code, 16);
    cyc(0,1,1,1,1,1,12'h0,2'd0); chk("R10 exit code", cmd_code, 15);
    chk("R10 awake", pwr_state, 0);
    cyc(1,0,1,1,1,1,12'h0,2'd0); chk("R10 pd code", cmd_code, 14);
    chk("R10 precharge pd", pwr_state, 1);
    cyc(0,1,1,1,1,1,12'h0,2'd0); chk("R10 exit", pwr_state, 0);
    act(1);
    cyc(1,0,0,1,1,1,12'h0,2'd0); chk("R10 active pd", pwr_state, 2);
    cyc(0,1,1,1,1,1,12'h0,2'd0); chk("R10 exit active", pwr_state, 0);
    prea(); idle(4);

    // R2 selected vs all precharge
    act(0); act(1); chk("R5 two open", bank_open, 4'b0011);
    pre(0); chk("R2 single pre", bank_open, 4'b0010);
    chk("R5 busy after pre", bank_busy, 4'b0001);
    idle(3);
    act(0); chk("R5 reopen", bank_open, 4'b0011);
    prea(); chk("R2 prea ignores bank", bank_open, 4'b0000);
    idle(4);

    // R8 illegal commands
    rd(2, 0); chk("R8 read closed", illegal_cmd, 1);
    act(2); chk("R8 act ok", illegal_cmd, 0);
    act(2); chk("R8 act open", illegal_cmd, 1);
    wr(2, 0); chk("R8 write open ok", illegal_cmd, 0);
    chk("R8 still open", bank_open, 4'b0100);
    cyc(1,1,0,1,1,0,12'h0,2'd2); chk("R8 bst ok", illegal_cmd, 0);
    cyc(1,1,0,1,1,0,12'h0,2'd3); chk("R8 bst closed", illegal_cmd, 1);

    // R3 / R4 mode register
    cyc(1,1,0,0,0,0,12'h123,2'd2); chk("R3 mrs code", cmd_code, 11);
    chk("R3 op", mode_op, 14'h2123);
    chk("R4 open viol", mode_viol, 1);
    prea(); idle(4);
    cyc(1,1,0,0,0,0,12'hABC,2'd1); chk("R3 emrs code", cmd_code, 12);
    chk("R3 eop", mode_op, 14'h1ABC);
    chk("R4 settled", mode_viol, 0);
    for (int t = 1; t <= 4; t++)
      for (int k = 1; k <= 5; k++) begin
        cfg_trp = 4'(t);
        act(0); pre(0);
        idle(k-1);
        cyc(1,1,0,0,0,0,12'h0,2'd0);
        chk("R4 mrs after pre", mode_viol, (k < t) ? 1 : 0);
        idle(6);
      end

    // R6 / R7 lockout sweeps
    for (int bl = 0; bl < 3; bl++)
      for (int t = 1; t <= 3; t++)
        for (int r = 1; r <= 3; r++)
          for (int m = 0; m < 2; m++) begin
            int win;
            win = (1 << bl) + t + ((m == 1) ? (1 + r) : 0);
            for (int k = 1; k <= win; k++) begin
              int b;
              b = (k + bl) % 4;
              cfg_burst = 2'(bl); cfg_trp = 4'(t); cfg_twr = 4'(r);
              act(b);
              if (m == 0) rd(b, 1); else wr(b, 1);
              idle(k-1);
              act(b);
              if (m == 0) begin
                chk("R6 early act", early_act, (k < win) ? 1 : 0);
                chk("R6 open state", bank_open[b], (k < win) ? 0 : 1);
              end else begin
                chk("R7 early act", early_act, (k < win) ? 1 : 0);
                chk("R7 open state", bank_open[b], (k < win) ? 0 : 1);
              end
              prea(); idle(win + 1);
            end
          end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule